// File: doc/BRIEF.md
# Edge-Programmable Pulse Counter

This block counts transitions on a single external pin into a 16-bit register. Software selects whether a low-to-high or a high-to-low transition counts, and can read or preset the count one byte at a time through a small register port. Reads, writes and the read data all complete in the same clock cycle.

In the default continuous mode the pin passes through a two-flop synchronizer and is compared with its previous synchronized value on every clock. In the polled mode the pin is looked at only once every 2^POLL_SHIFT clocks. An edge is then a difference between two successive looks. This lets a pull-up on the pin be duty-cycled, at the cost of missing pulses that fall between two looks.

Reading the low byte captures the high byte at the same time, so a following read of the high byte gives a value that belongs with the low byte already read.

Top module: `edge_event_counter`

## Requirements
- R1: After reset the count is 0x0000, the control register is 0x00 (rising edge, continuous mode) and the captured high byte is 0x00.
- R2: The control register is at address 0x0D. Bit 0 selects the falling edge when 1 and the rising edge when 0. Bit 1 selects polled mode when 1. It reads back with bits 7:2 as zero.
- R3: In continuous mode every selected edge of the pin adds exactly one to the count, including pulses one clock wide. A pin change driven before rising clock edge k shows in the count after edge k+2.
- R4: The count wraps from 0xFFFF to 0x0000 on the next selected edge.
- R5: A read at address 0x0E returns count bits 7:0 and captures count bits 15:8. A read at address 0x0F returns the captured byte, not the live high byte.
- R6: In polled mode the synchronized pin is sampled once every 2^POLL_SHIFT clocks. The first sample falls on the 2^POLL_SHIFT-th rising edge after reset. An edge counts only as a difference of the selected direction between two successive samples, so a pulse that lies wholly between samples is not counted.
- R7: bus_rdata is combinational from the read request. It is 0x00 whenever bus_rd is low or the address is not 0x0D, 0x0E or 0x0F.
- R8: A write at 0x0E or 0x0F replaces that byte of the count and leaves the other byte as it was. An increment due in the same cycle is discarded.
- R9: Writes to any address other than 0x0D, 0x0E and 0x0F change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_pin | input | 1 | External count pin, asynchronous |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd | input | 1 | Read strobe, one cycle |
| bus_rdata | output | 8 | Read data, valid in the strobe cycle |

## Verification
The count register, the sampling phase and the captured high byte are all hidden state, so a wrong internal value reaches the ports only through a read. The bench therefore reads the registers on almost every cycle and compares bus_rdata with a behavioural model every clock. A wrong reference value, a lost or doubled increment, or a wrong sample phase shows as a count off by one at the next low-byte read, within one sample period in polled mode. A stale or wrongly timed capture shows at the very next high-byte read.

// File: rtl/edge_event_counter.sv
module edge_event_counter #(
  parameter int POLL_SHIFT = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_pin,
  input  logic [7:0] bus_addr,
  input  logic       bus_wr,
  input  logic [7:0] bus_wdata,
  input  logic       bus_rd,
  output logic [7:0] bus_rdata
);
  localparam logic [7:0] A_CTRL = 8'h0D;
  localparam logic [7:0] A_LO   = 8'h0E;
  localparam logic [7:0] A_HI   = 8'h0F;

  logic [1:0]            sync_q;
  logic                  ref_q;
  logic                  fall_sel_q;
  logic                  poll_q;
  logic [POLL_SHIFT-1:0] div_q;
  logic [15:0]           count_q;
  logic [7:0]            hi_snap_q;

  logic tick, sample_en, pin_s, hit, wr_lo, wr_hi;

  assign pin_s     = sync_q[1];
  assign tick      = &div_q;
  assign sample_en = !poll_q || tick;
  assign hit       = sample_en && (pin_s != ref_q) && (pin_s != fall_sel_q);
  assign wr_lo     = bus_wr && (bus_addr == A_LO);
  assign wr_hi     = bus_wr && (bus_addr == A_HI);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      ref_q      <= 1'b0;
      fall_sel_q <= 1'b0;
      poll_q     <= 1'b0;
      div_q      <= '0;
      count_q    <= '0;
      hi_snap_q  <= '0;
    end else begin
      sync_q <= {sync_q[0], cnt_pin};
      div_q  <= div_q + 1'b1;
      if (sample_en) ref_q <= pin_s;
      if (wr_lo || wr_hi) begin
        if (wr_lo) count_q[7:0]  <= bus_wdata;
        if (wr_hi) count_q[15:8] <= bus_wdata;
      end else if (hit) begin
        count_q <= count_q + 16'd1;
      end
      if (bus_wr && (bus_addr == A_CTRL)) {poll_q, fall_sel_q} <= bus_wdata[1:0];
      if (bus_rd && (bus_addr == A_LO)) hi_snap_q <= count_q[15:8];
    end
  end

  always_comb begin
    bus_rdata = 8'h00;
    if (bus_rd) begin
      case (bus_addr)
        A_CTRL:  bus_rdata = {6'b0, poll_q, fall_sel_q};
        A_LO:    bus_rdata = count_q[7:0];
        A_HI:    bus_rdata = hi_snap_q;
        default: bus_rdata = 8'h00;
      endcase
    end
  end
endmodule

// File: rtl/edge_event_counter_chk.sv
module edge_event_counter_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [7:0]  bus_addr,
  input logic        bus_wr,
  input logic [7:0]  bus_wdata,
  input logic        bus_rd,
  input logic [7:0]  bus_rdata,
  input logic        poll,
  input logic        tick,
  input logic [15:0] count,
  input logic [7:0]  hi_snap
);
  logic cnt_write;
  assign cnt_write = bus_wr && (bus_addr == 8'h0E || bus_addr == 8'h0F);

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_write |=> (count == $past(count) || count == $past(count) + 16'd1));

  a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    (count == 16'hFFFF && !cnt_write) |=> (count == 16'hFFFF || count == 16'h0000));

  a_r5_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == 8'h0E) |=> hi_snap == $past(count[15:8]));

  a_r6_poll_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (poll && !tick && !cnt_write) |=> $stable(count));

  a_r7_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_rd |-> bus_rdata == 8'h00);

  a_r8_low_load: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 8'h0E) |=> count[7:0] == $past(bus_wdata));
endmodule

bind edge_event_counter edge_event_counter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
  .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
  .poll(poll_q), .tick(tick), .count(count_q), .hi_snap(hi_snap_q)
);

// File: tb/edge_event_counter_tb.sv
`timescale 1ns/1ps
module edge_event_counter_tb;
  localparam int SHIFT = 4;
  localparam int PER   = 1 << SHIFT;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cnt_pin = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic bus_rd = 1'b0;
  logic [7:0] bus_rdata;

  int vectors = 0;
  int fails = 0;

  always #4 clk = ~clk;

  edge_event_counter #(.POLL_SHIFT(SHIFT)) u_dut (
    .clk(clk), .rst_n(rst_n), .cnt_pin(cnt_pin), .bus_addr(bus_addr),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  // behavioural reference
  logic pq[$] = '{1'b0, 1'b0};
  logic [15:0] m_cnt;
  logic [7:0]  m_snap;
  logic m_fall, m_poll, m_ref;
  int m_cyc;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pq = '{1'b0, 1'b0};
      m_cnt = '0; m_snap = '0; m_fall = 0; m_poll = 0; m_ref = 0; m_cyc = 0;
    end else begin
      logic s, en, inc, tk;
      tk = (m_cyc % PER) == PER - 1;
      m_cyc++;
      s = pq.pop_front();
      pq.push_back(cnt_pin);
      en = !m_poll || tk;
      inc = en && (s != m_ref) && (m_fall ? !s : s);
      if (en) m_ref = s;
      if (bus_rd && bus_addr == 8'h0E) m_snap = m_cnt[15:8];
      if (bus_wr && (bus_addr == 8'h0E || bus_addr == 8'h0F)) begin
        if (bus_addr == 8'h0E) m_cnt[7:0] = bus_wdata;
        else m_cnt[15:8] = bus_wdata;
      end else if (inc) m_cnt = m_cnt + 16'd1;
      if (bus_wr && bus_addr == 8'h0D) begin
        m_fall = bus_wdata[0]; m_poll = bus_wdata[1];
      end
    end
  end

  function automatic logic [7:0] model_rdata();
    if (!bus_rd) return 8'h00;
    case (bus_addr)
      8'h0D: return {6'b0, m_poll, m_fall};
      8'h0E: return m_cnt[7:0];
      8'h0F: return m_snap;
      default: return 8'h00;
    endcase
  endfunction

  task automatic step(input logic pin, input logic wr, input logic rd,
                      input logic [7:0] a, input logic [7:0] d, input string tag);
    @(negedge clk);
    cnt_pin = pin; bus_wr = wr; bus_rd = rd; bus_addr = a; bus_wdata = d;
    #1;
    vectors++;
    if (bus_rdata !== model_rdata()) begin
      fails++;
      $display("FAIL %s: rdata=%h expected=%h", tag, bus_rdata, model_rdata());
    end
  endtask

  task automatic idle(input int n, input logic pin, input string tag);
    for (int i = 0; i < n; i++) step(pin, 0, 0, 8'h00, 8'h00, tag);
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d, input string tag);
    step(cnt_pin, 1, 0, a, d, tag);
  endtask

  task automatic expect_rd(input logic [7:0] a, input logic [7:0] exp, input string tag);
    step(cnt_pin, 0, 1, a, 8'h00, tag);
    vectors++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s: addr %h read %h expected %h", tag, a, bus_rdata, exp);
    end
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    expect_rd(8'h0D, 8'h00, "R1 ctrl");
    expect_rd(8'h0E, 8'h00, "R1 low");
    expect_rd(8'h0F, 8'h00, "R1 high");
    // R3 latency: visible after third edge
    step(1, 0, 0, 8'h00, 8'h00, "R3");
    expect_rd(8'h0E, 8'h00, "R3 lat1");
    expect_rd(8'h0E, 8'h00, "R3 lat2");
    expect_rd(8'h0E, 8'h01, "R3 lat3");
    idle(4, 0, "R3");
    idle(4, 1, "R3");
    idle(4, 0, "R3");
    step(1, 0, 0, 8'h00, 8'h00, "R3");
    idle(5, 0, "R3");
    expect_rd(8'h0E, 8'h03, "R3 one-cycle pulse");
    // R2 falling polarity
    wr(8'h0D, 8'hFD, "R2");
    expect_rd(8'h0D, 8'h01, "R2 ctrl readback");
    idle(6, 1, "R2");
    expect_rd(8'h0E, 8'h03, "R2 rising ignored");
    idle(6, 0, "R2");
    expect_rd(8'h0E, 8'h04, "R2 falling counted");
    // R8 / R4
    wr(8'h0E, 8'hFF, "R8");
    wr(8'h0F, 8'hFF, "R8");
    expect_rd(8'h0E, 8'hFF, "R8 low load");
    expect_rd(8'h0F, 8'hFF, "R8 high load");
    idle(6, 1, "R4");
    idle(6, 0, "R4");
    expect_rd(8'h0E, 8'h00, "R4 wrap low");
    expect_rd(8'h0F, 8'h00, "R4 wrap high");
    // R5 coherent capture
    wr(8'h0E, 8'hFF, "R5");
    wr(8'h0F, 8'h12, "R5");
    expect_rd(8'h0E, 8'hFF, "R5 low");
    idle(6, 1, "R5");
    idle(6, 0, "R5");
    expect_rd(8'h0F, 8'h12, "R5 captured high");
    expect_rd(8'h0E, 8'h00, "R5 low after carry");
    expect_rd(8'h0F, 8'h13, "R5 recaptured high");
    // R8 collision with increment
    wr(8'h0D, 8'h00, "R8");
    wr(8'h0E, 8'h00, "R8");
    wr(8'h0F, 8'h00, "R8");
    step(1, 0, 0, 8'h00, 8'h00, "R8");
    step(1, 0, 0, 8'h00, 8'h00, "R8");
    step(1, 1, 0, 8'h0E, 8'h55, "R8");
    idle(3, 1, "R8");
    expect_rd(8'h0E, 8'h55, "R8 collision low");
    expect_rd(8'h0F, 8'h00, "R8 collision high");
    // R9 / R7 unused address
    wr(8'h20, 8'hAA, "R9");
    expect_rd(8'h0D, 8'h00, "R9 ctrl untouched");
    expect_rd(8'h0E, 8'h55, "R9 count untouched");
    expect_rd(8'h20, 8'h00, "R7 unused read");
    step(1, 0, 0, 8'h0E, 8'h00, "R7");
    vectors++;
    if (bus_rdata !== 8'h00) begin
      fails++;
      $display("FAIL R7: idle rdata %h expected 00", bus_rdata);
    end
    // R6 polled mode
    idle(4, 0, "R6");
    wr(8'h0D, 8'h02, "R6");
    wr(8'h0E, 8'h00, "R6");
    while (m_cyc % PER != 1) idle(1, 0, "R6");
    idle(4, 1, "R6");
    idle(40, 0, "R6");
    expect_rd(8'h0E, 8'h00, "R6 short pulse missed");
    idle(40, 1, "R6");
    expect_rd(8'h0E, 8'h01, "R6 long high counted");
    idle(40, 0, "R6");
    expect_rd(8'h0E, 8'h01, "R6 falling ignored");
    // mixed random traffic, model compared every clock
    for (int i = 0; i < 600; i++) begin
      logic p;
      p = 1'($urandom_range(0, 1));
      for (int j = 0, n = $urandom_range(1, 20); j < n; j++) begin
        int r;
        r = $urandom_range(0, 99);
        if (r < 3)       step(p, 1, 0, 8'h0D, 8'($urandom_range(0, 255)), "R2 R6 mix");
        else if (r < 5)  step(p, 1, 0, 8'h0E + 8'($urandom_range(0, 1)), 8'($urandom_range(0, 255)), "R8 mix");
        else if (r < 60) step(p, 0, 1, 8'h0D + 8'($urandom_range(0, 2)), 8'h00, "R3 R5 mix");
        else             step(p, 0, 0, 8'h00, 8'h00, "R3 mix");
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule